// File: doc/BRIEF.md
# Big-Number Engine Microprogram Sequencer

This block sequences microprograms for a big-number arithmetic engine. A host fills a word-addressed instruction store through a simple write port. It then writes a command word that names the first instruction to run. The sequencer fetches each 32-bit instruction and splits it into an opcode, register selectors and a length operand. It hands every arithmetic, shift and tag instruction to an external execution unit over a valid/ready handshake. It then waits for that unit's completion pulse before fetching the next word.

Branch, call and return are resolved inside the sequencer and are never shown to the execution unit. Call and return use a small hardware return-address stack. Any instruction can carry an end-of-program flag. Once such an instruction has completed, the sequencer returns to idle. While idle, it raises its idle status bit and, if enabled, an interrupt line. A stack overflow or underflow stops the program at once and flags an error. The execution unit itself is not part of this block.

Top module: `pk_microseq`

## Requirements
- R1: After reset the sequencer is idle. `stat_word` reads 0x0000_8000 (bit 15 idle set, bit 3 carry clear, bit 1 error clear), `irq` is 0 and `ex_valid` is 0.
- R2: A write to byte address 0x1FD4 while idle starts execution. The first instruction issued is the word at index `wdata[8:2]`. Instruction word i is written at byte address 0x1100 + 4*i, for i from 0 to 127.
- R3: An issued instruction word w appears as `ex_op`=w[30:26], `ex_rd`=w[25:21], `ex_ra`=w[20:16], `ex_rb`=w[15:11], `ex_rm`=w[10:6] and `ex_len`=w[15:0]. All of these, and `ex_valid`, stay stable until `ex_ready` is seen.
- R4: After the execution unit pulses `ex_done`, the next fetch is from the following index, and index 127 wraps to 0.
- R5: An instruction with bit 31 set ends the program once it completes. The sequencer goes idle, and status bit 15 reads 1.
- R6: Opcode 15 (branch) continues at index `w[6:0]` and is not issued to the execution unit.
- R7: Opcode 16 (call) pushes the following index and jumps to `w[6:0]`. Opcode 17 (return) pops that index and continues there. Four nested calls are allowed. Neither opcode is issued to the execution unit.
- R8: A fifth nested call, or a return with an empty stack, forces idle and sets status bit 1. Starting the next program clears that bit.
- R9: A command write while the sequencer is busy is ignored. This includes the cycle in which the last instruction completes.
- R10: Bit 15 of the interrupt-enable register (byte address 0x1FDC) routes the idle condition to `irq`.
- R11: Status bit 3 shows `ex_carry` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 13 | Host byte address |
| host_wdata | input | 32 | Host write data |
| stat_word | output | 32 | Status: bit 15 idle, bit 3 carry, bit 1 stack error |
| irq | output | 1 | Idle interrupt |
| ex_valid | output | 1 | Instruction offered to execution unit |
| ex_ready | input | 1 | Execution unit accepts the instruction |
| ex_op | output | 5 | Opcode |
| ex_rd | output | 5 | Destination register |
| ex_ra | output | 5 | Source register A |
| ex_rb | output | 5 | Source register B |
| ex_rm | output | 5 | Modulus register |
| ex_len | output | 16 | Length operand |
| ex_done | input | 1 | Execution unit finished the accepted instruction |
| ex_carry | input | 1 | Carry flag from execution unit |

## Verification
Two events can land on the same clock edge: a host command write, and the completion of a program's final instruction, which drops the sequencer to idle. The bench's execution model raises the command write in exactly the cycle it pulses `ex_done` for the last expected instruction. The sequencer must stay idle afterwards and must offer no instruction. An unexpected offer would be reported by the scoreboard as an issue with no expected item.

// File: rtl/pk_microseq_pkg.sv
package pk_microseq_pkg;

   // host byte addresses
   localparam logic [12:0] IMEM_BASE = 13'h1100;
   localparam logic [12:0] CMD_ADDR  = 13'h1FD4;
   localparam logic [12:0] IEN_ADDR  = 13'h1FDC;

   // bit positions
   localparam int CMD_OFS_LSB  = 2;
   localparam int ST_IDLE_BIT  = 15;
   localparam int ST_CARRY_BIT = 3;
   localparam int ST_ERR_BIT   = 1;
   localparam int IEN_IDLE_BIT = 15;

   // control-flow opcodes handled locally
   localparam logic [4:0] OP_BRANCH = 5'd15;
   localparam logic [4:0] OP_CALL   = 5'd16;
   localparam logic [4:0] OP_RET    = 5'd17;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_FETCH = 2'd1,
      S_ISSUE = 2'd2,
      S_WAIT  = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic        last;
      logic [4:0]  op;
      logic [4:0]  rd;
      logic [4:0]  ra;
      logic [4:0]  rb;
      logic [4:0]  rm;
      logic [15:0] len;
   } instr_t;

   function automatic instr_t split_word(input logic [31:0] w);
      instr_t r;
      r.last = w[31];
      r.op   = w[30:26];
      r.rd   = w[25:21];
      r.ra   = w[20:16];
      r.rb   = w[15:11];
      r.rm   = w[10:6];
      r.len  = w[15:0];
      return r;
   endfunction

   function automatic logic is_flow_op(input logic [4:0] op);
      return (op == OP_BRANCH) || (op == OP_CALL) || (op == OP_RET);
   endfunction

endpackage

// File: rtl/pk_microseq_imem.sv
module pk_microseq_imem #(
   parameter int WORDS = 128,
   parameter int WIDTH = 32,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store_q [WORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         store_q[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (re) begin
         rdata <= store_q[raddr];
      end
   end

endmodule

// File: rtl/pk_microseq_rstack.sv
module pk_microseq_rstack #(
   parameter int DEPTH = 4,
   parameter int AW    = 7,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top_data,
   output logic          full,
   output logic          empty
);

   logic [CW-1:0] fill_q;
   logic [AW-1:0] slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (clr) begin
         fill_q <= '0;
      end else if (push && !full) begin
         fill_q <= fill_q + CW'(1);
      end else if (pop && !empty) begin
         fill_q <= fill_q - CW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!clr && push && (fill_q == CW'(i))) begin
            slot_q[i] <= push_data;
         end
      end
   end

   always_comb begin
      top_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (fill_q == CW'(i + 1)) begin
            top_data = slot_q[i];
         end
      end
   end

   assign full  = (fill_q == CW'(DEPTH));
   assign empty = (fill_q == '0);

endmodule

// File: rtl/pk_microseq_ctrl.sv
module pk_microseq_ctrl
   import pk_microseq_pkg::*;
#(
   parameter int PC_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_go,
   input  logic [PC_W-1:0] cmd_ofs,
   input  logic [31:0]     ir_word,
   output logic            fetch_en,
   output logic [PC_W-1:0] fetch_addr,
   output logic            stk_clr,
   output logic            stk_push,
   output logic            stk_pop,
   output logic [PC_W-1:0] stk_wdata,
   input  logic [PC_W-1:0] stk_top,
   input  logic            stk_full,
   input  logic            stk_empty,
   output logic            ex_valid,
   input  logic            ex_ready,
   input  logic            ex_done,
   output instr_t          ex_instr,
   output logic            idle,
   output logic            err
);

   seq_state_e      state_q, state_d;
   logic [PC_W-1:0] pc_q, pc_d;
   logic            err_q, err_d;
   instr_t          ir;
   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] target;
   seq_state_e      after_flow;

   assign ir         = split_word(ir_word);
   assign pc_inc     = pc_q + PC_W'(1);
   assign target     = ir.len[PC_W-1:0];
   assign after_flow = ir.last ? S_IDLE : S_FETCH;

   always_comb begin
      state_d   = state_q;
      pc_d      = pc_q;
      err_d     = err_q;
      stk_clr   = 1'b0;
      stk_push  = 1'b0;
      stk_pop   = 1'b0;
      stk_wdata = pc_inc;
      ex_valid  = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (cmd_go) begin
               state_d = S_FETCH;
               pc_d    = cmd_ofs;
               err_d   = 1'b0;
               stk_clr = 1'b1;
            end
         end
         S_FETCH: begin
            state_d = S_ISSUE;
         end
         S_ISSUE: begin
            if (is_flow_op(ir.op)) begin
               case (ir.op)
                  OP_BRANCH: begin
                     pc_d    = target;
                     state_d = after_flow;
                  end
                  OP_CALL: begin
                     if (stk_full) begin
                        state_d = S_IDLE;
                        err_d   = 1'b1;
                     end else begin
                        stk_push = 1'b1;
                        pc_d     = target;
                        state_d  = after_flow;
                     end
                  end
                  default: begin
                     if (stk_empty) begin
                        state_d = S_IDLE;
                        err_d   = 1'b1;
                     end else begin
                        stk_pop = 1'b1;
                        pc_d    = stk_top;
                        state_d = after_flow;
                     end
                  end
               endcase
            end else begin
               ex_valid = 1'b1;
               if (ex_ready) begin
                  state_d = S_WAIT;
                  pc_d    = pc_inc;
               end
            end
         end
         S_WAIT: begin
            if (ex_done) begin
               state_d = ir.last ? S_IDLE : S_FETCH;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pc_q    <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         err_q   <= err_d;
      end
   end

   assign fetch_en   = (state_q == S_FETCH);
   assign fetch_addr = pc_q;
   assign ex_instr   = ir;
   assign idle       = (state_q == S_IDLE);
   assign err        = err_q;

endmodule

// File: rtl/pk_microseq.sv
module pk_microseq
   import pk_microseq_pkg::*;
#(
   parameter int IMEM_WORDS  = 128,
   parameter int STACK_DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [12:0] host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] stat_word,
   output logic        irq,
   output logic        ex_valid,
   input  logic        ex_ready,
   output logic [4:0]  ex_op,
   output logic [4:0]  ex_rd,
   output logic [4:0]  ex_ra,
   output logic [4:0]  ex_rb,
   output logic [4:0]  ex_rm,
   output logic [15:0] ex_len,
   input  logic        ex_done,
   input  logic        ex_carry
);

   localparam int PC_W      = $clog2(IMEM_WORDS);
   localparam int WIN_BYTES = 4 * IMEM_WORDS;

   if (IMEM_WORDS != (1 << PC_W)) begin : g_bad_words
      $error("IMEM_WORDS must be a power of two");
   end
   if (PC_W > 7 || PC_W < 1) begin : g_bad_span
      $error("IMEM_WORDS must lie between 2 and 128");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("STACK_DEPTH must be at least one");
   end

   logic            imem_hit;
   logic [12:0]     imem_off;
   logic [PC_W-1:0] imem_widx;
   logic            cmd_go;
   logic [PC_W-1:0] cmd_ofs;
   logic            fetch_en;
   logic [PC_W-1:0] fetch_addr;
   logic [31:0]     ir_word;
   logic            stk_clr, stk_push, stk_pop, stk_full, stk_empty;
   logic [PC_W-1:0] stk_wdata, stk_top;
   instr_t          cur;
   logic            idle, err;
   logic            ien_q;
   logic            carry_q;

   assign imem_off  = host_addr - IMEM_BASE;
   assign imem_hit  = host_wr && (host_addr >= IMEM_BASE)
                      && ({1'b0, imem_off} < 14'(WIN_BYTES))
                      && (host_addr[1:0] == 2'b00);
   assign imem_widx = imem_off[PC_W+1:2];
   assign cmd_go    = host_wr && (host_addr == CMD_ADDR);
   assign cmd_ofs   = host_wdata[CMD_OFS_LSB +: PC_W];

   pk_microseq_imem #(
      .WORDS (IMEM_WORDS),
      .WIDTH (32)
   ) imem_i (
      .clk   (clk),
      .we    (imem_hit),
      .waddr (imem_widx),
      .wdata (host_wdata),
      .re    (fetch_en),
      .raddr (fetch_addr),
      .rdata (ir_word)
   );

   pk_microseq_rstack #(
      .DEPTH (STACK_DEPTH),
      .AW    (PC_W)
   ) rstack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (stk_clr),
      .push      (stk_push),
      .pop       (stk_pop),
      .push_data (stk_wdata),
      .top_data  (stk_top),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   pk_microseq_ctrl #(
      .PC_W (PC_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_go     (cmd_go),
      .cmd_ofs    (cmd_ofs),
      .ir_word    (ir_word),
      .fetch_en   (fetch_en),
      .fetch_addr (fetch_addr),
      .stk_clr    (stk_clr),
      .stk_push   (stk_push),
      .stk_pop    (stk_pop),
      .stk_wdata  (stk_wdata),
      .stk_top    (stk_top),
      .stk_full   (stk_full),
      .stk_empty  (stk_empty),
      .ex_valid   (ex_valid),
      .ex_ready   (ex_ready),
      .ex_done    (ex_done),
      .ex_instr   (cur),
      .idle       (idle),
      .err        (err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= 1'b0;
         carry_q <= 1'b0;
      end else begin
         carry_q <= ex_carry;
         if (host_wr && (host_addr == IEN_ADDR)) begin
            ien_q <= host_wdata[IEN_IDLE_BIT];
         end
      end
   end

   always_comb begin
      stat_word               = '0;
      stat_word[ST_IDLE_BIT]  = idle;
      stat_word[ST_CARRY_BIT] = carry_q;
      stat_word[ST_ERR_BIT]   = err;
   end

   assign irq    = idle && ien_q;
   assign ex_op  = cur.op;
   assign ex_rd  = cur.rd;
   assign ex_ra  = cur.ra;
   assign ex_rb  = cur.rb;
   assign ex_rm  = cur.rm;
   assign ex_len = cur.len;

endmodule

// File: rtl/pk_microseq_chk.sv
module pk_microseq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_wr,
   input logic [12:0] host_addr,
   input logic [31:0] stat_word,
   input logic        irq,
   input logic        ex_valid,
   input logic        ex_ready,
   input logic [4:0]  ex_op,
   input logic [4:0]  ex_rd,
   input logic [4:0]  ex_ra,
   input logic [15:0] ex_len,
   input logic        ex_carry
);

   AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid && !ex_ready |=> ex_valid && $stable({ex_op, ex_rd, ex_ra, ex_len})); // R3

   AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[15] |-> !ex_valid); // R5

   AST_IRQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_word[15]); // R10

   AST_ERR_IMPLIES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[1] |-> stat_word[15]); // R8

   AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[15] && host_wr && (host_addr == 13'h1FD4) |=> !stat_word[15] && !stat_word[1]); // R2

   AST_CARRY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> stat_word[3] == $past(ex_carry)); // R11

endmodule

bind pk_microseq pk_microseq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .host_addr (host_addr),
   .stat_word (stat_word),
   .irq       (irq),
   .ex_valid  (ex_valid),
   .ex_ready  (ex_ready),
   .ex_op     (ex_op),
   .ex_rd     (ex_rd),
   .ex_ra     (ex_ra),
   .ex_len    (ex_len),
   .ex_carry  (ex_carry)
);

// File: tb/pk_microseq_tb_top.sv
module pk_microseq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [12:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] stat_word;
   logic        irq;
   logic        ex_valid;
   logic        ex_ready = 1'b0;
   logic [4:0]  ex_op, ex_rd, ex_ra, ex_rb, ex_rm;
   logic [15:0] ex_len;
   logic        ex_done = 1'b0;
   logic        ex_carry = 1'b0;

   int checks = 0;
   int errors = 0;
   int pace = 0;
   bit race_arm = 1'b0;
   logic [31:0] exp_q [$];

   localparam logic [12:0] CMD = 13'h1FD4;
   localparam logic [12:0] IEN = 13'h1FDC;

   always #5 clk = ~clk;

   pk_microseq dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .stat_word(stat_word), .irq(irq),
      .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_op(ex_op), .ex_rd(ex_rd),
      .ex_ra(ex_ra), .ex_rb(ex_rb), .ex_rm(ex_rm), .ex_len(ex_len),
      .ex_done(ex_done), .ex_carry(ex_carry)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [31:0] mk3(input bit last, input int op, input int rd,
                                       input int ra, input int rb, input int rm);
      return {last, 5'(op), 5'(rd), 5'(ra), 5'(rb), 5'(rm), 6'd0};
   endfunction

   function automatic logic [31:0] mk2(input bit last, input int op, input int rd,
                                       input int ra, input int len);
      return {last, 5'(op), 5'(rd), 5'(ra), 16'(len)};
   endfunction

   task automatic host_write(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic put(input int idx, input logic [31:0] w);
      host_write(13'h1100 + 13'(idx * 4), w);
   endtask

   task automatic start(input int ofs);
      host_write(CMD, 32'(ofs) << 2);
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (!stat_word[15] && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check(stat_word[15], {tag, " program reached idle"}, stat_word, 32'h8000);
      check(exp_q.size() == 0, {tag, " all expected issues seen"}, exp_q.size(), 0);
   endtask

   // execution-unit model and scoreboard monitor (R3)
   initial begin
      forever begin
         @(negedge clk);
         if (ex_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 unexpected issue", {ex_op, ex_rd, ex_ra, ex_len[15:0], 1'b0}, 0);
            end else begin
               logic [31:0] w;
               w = exp_q.pop_front();
               check({ex_op, ex_rd, ex_ra, ex_rb, ex_rm, ex_len} ==
                     {w[30:26], w[25:21], w[20:16], w[15:11], w[10:6], w[15:0]},
                     "R3 issued fields",
                     {1'b0, ex_op, ex_rd, ex_ra, ex_len}, {1'b0, w[30:0]});
            end
            repeat (pace % 3) @(negedge clk);
            ex_ready = 1'b1;
            @(negedge clk);
            ex_ready = 1'b0;
            repeat (pace % 2) @(negedge clk);
            ex_done = 1'b1;
            if (race_arm && exp_q.size() == 0) begin
               host_wr = 1'b1; host_addr = CMD; host_wdata = 32'd5 << 2;
               race_arm = 1'b0;
               @(negedge clk);
               host_wr = 1'b0;
            end else begin
               @(negedge clk);
            end
            ex_done = 1'b0;
            pace++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(stat_word == 32'h0000_8000, "R1 status after reset", stat_word, 32'h8000);
      check(irq == 1'b0, "R1 irq after reset", irq, 0);
      check(ex_valid == 1'b0, "R1 no offer during reset", ex_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(stat_word == 32'h0000_8000, "R1 status after release", stat_word, 32'h8000);

      // R2 R4 R5: straight line from offset 5, shift/tag length fields
      put(5, mk3(0, 5, 1, 2, 3, 4));
      put(6, mk2(0, 11, 2, 2, 16'h00A3));
      put(7, mk2(1, 14, 3, 3, 16'h0200));
      put(8, mk3(0, 6, 9, 9, 9, 9));
      exp_q.push_back(mk3(0, 5, 1, 2, 3, 4));
      exp_q.push_back(mk2(0, 11, 2, 2, 16'h00A3));
      exp_q.push_back(mk2(1, 14, 3, 3, 16'h0200));
      start(5);
      check(stat_word[15] == 1'b0, "R2 busy after command", stat_word, 0);
      wait_idle("R5");

      // R4 wrap from index 127 to 0
      put(127, mk3(0, 9, 7, 6, 5, 4));
      put(0, mk2(1, 12, 1, 1, 16'h0001));
      exp_q.push_back(mk3(0, 9, 7, 6, 5, 4));
      exp_q.push_back(mk2(1, 12, 1, 1, 16'h0001));
      start(127);
      wait_idle("R4");

      // R6 R7: branch, call, return
      put(20, mk2(0, 15, 0, 0, 30));
      put(21, mk3(0, 5, 1, 1, 1, 1));
      put(30, mk2(0, 16, 0, 0, 40));
      put(31, mk3(1, 4, 2, 2, 2, 2));
      put(40, mk3(0, 1, 3, 4, 5, 6));
      put(41, mk2(0, 17, 0, 0, 0));
      exp_q.push_back(mk3(0, 1, 3, 4, 5, 6));
      exp_q.push_back(mk3(1, 4, 2, 2, 2, 2));
      start(20);
      wait_idle("R6 R7");
      check(stat_word[1] == 1'b0, "R7 no stack error", stat_word, 0);

      // R7 four nested calls, full-depth boundary
      put(80, mk2(0, 16, 0, 0, 90));
      put(81, mk2(1, 13, 4, 4, 16'h0003));
      put(90, mk2(0, 16, 0, 0, 100));
      put(91, mk2(0, 17, 0, 0, 0));
      put(100, mk2(0, 16, 0, 0, 110));
      put(101, mk2(0, 17, 0, 0, 0));
      put(110, mk2(0, 16, 0, 0, 120));
      put(111, mk2(0, 17, 0, 0, 0));
      put(120, mk3(0, 3, 8, 9, 10, 11));
      put(121, mk2(0, 17, 0, 0, 0));
      exp_q.push_back(mk3(0, 3, 8, 9, 10, 11));
      exp_q.push_back(mk2(1, 13, 4, 4, 16'h0003));
      start(80);
      wait_idle("R7 depth4");
      check(stat_word[1] == 1'b0, "R7 depth four legal", stat_word, 0);

      // R8 overflow on fifth nested call
      put(50, mk2(0, 16, 0, 0, 55));
      put(55, mk2(0, 16, 0, 0, 56));
      put(56, mk2(0, 16, 0, 0, 57));
      put(57, mk2(0, 16, 0, 0, 58));
      put(58, mk2(0, 16, 0, 0, 59));
      put(59, mk3(1, 5, 1, 1, 1, 1));
      start(50);
      wait_idle("R8 overflow");
      check(stat_word[1] == 1'b1, "R8 overflow error bit", stat_word, 32'h8002);

      // R8 underflow on return with empty stack
      put(70, mk2(0, 17, 0, 0, 0));
      put(71, mk3(1, 5, 1, 1, 1, 1));
      start(70);
      wait_idle("R8 underflow");
      check(stat_word[1] == 1'b1, "R8 underflow error bit", stat_word, 32'h8002);

      // R8 error cleared by next start; R9 command while busy ignored
      exp_q.push_back(mk3(0, 5, 1, 2, 3, 4));
      exp_q.push_back(mk2(0, 11, 2, 2, 16'h00A3));
      exp_q.push_back(mk2(1, 14, 3, 3, 16'h0200));
      start(5);
      check(stat_word[1] == 1'b0, "R8 error cleared on start", stat_word, 0);
      start(20);
      wait_idle("R9 busy command");

      // R10 interrupt enable
      check(irq == 1'b0, "R10 irq masked", irq, 0);
      host_write(IEN, 32'h0000_8000);
      check(irq == 1'b1, "R10 irq when idle and enabled", irq, 1);
      put(10, mk3(1, 2, 1, 1, 1, 1));
      exp_q.push_back(mk3(1, 2, 1, 1, 1, 1));
      start(10);
      check(irq == 1'b0, "R10 irq low while busy", irq, 0);
      wait_idle("R10");
      check(irq == 1'b1, "R10 irq back when idle", irq, 1);
      host_write(IEN, 32'h0000_7FFF);
      check(irq == 1'b0, "R10 irq disabled", irq, 0);

      // R9 command in the same cycle as the final completion
      exp_q.push_back(mk3(1, 2, 1, 1, 1, 1));
      race_arm = 1'b1;
      start(10);
      wait_idle("R9 race");
      repeat (12) @(negedge clk);
      check(stat_word[15] == 1'b1, "R9 command at completion ignored", stat_word, 32'h8000);

      // R11 carry mirror
      ex_carry = 1'b1;
      @(negedge clk);
      check(stat_word[3] == 1'b1, "R11 carry set", stat_word, 32'h8008);
      ex_carry = 1'b0;
      @(negedge clk);
      check(stat_word[3] == 1'b0, "R11 carry clear", stat_word, 32'h8000);

      summary();
   end

endmodule